// File: doc/BRIEF.md
# Configurable Asynchronous Frame Receiver

This block recovers bytes from an idle-high asynchronous serial line. An oversampling strobe, sixteen per bit time by default, comes from outside. The block watches for a falling edge and confirms the start bit half a bit later. It then samples every following bit at its centre. The data word is rebuilt from a least-significant-first stream of five to eight bits.

The frame shape is selected by a few static inputs, which are captured when a start edge is seen:
- the data length;
- an optional parity bit, checked by one of four rules;
- an optional unchecked ninth bit;
- one or two stop bits.

At the end of each frame the block pulses a one-cycle valid strobe. It presents the right-justified word, the bit that followed the data, a parity-error flag and a framing-error flag. These outputs hold until the next frame completes.

Top module: `cfg_uart_rx`

## Requirements
- R1: While idle, a high-to-low transition of the line (seen on oversampling ticks) starts a frame. If the line is high again at the start bit's midpoint, eight ticks later, the edge is dropped as a glitch and no strobe follows.
- R2: `len_sel` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The first data bit received lands in `rx_data[0]`, and bits above the selected length read zero.
- R3: With `par_en`=1 the bit after the data is a parity bit. It is compared with the expected value for the rule in `par_rule`: 0 even, 1 odd, 2 always-one, 3 always-zero. A mismatch sets `par_err`, and the received bit appears on `rx_ninth`.
- R4: With `par_en`=0 and `xbit_en`=1 the bit after the data is shown on `rx_ninth` unchecked, and `par_err` stays 0.
- R5: With `par_en`=1, `xbit_en` has no effect: the frame is received exactly as with `xbit_en`=0.
- R6: With both `par_en` and `xbit_en` at 0, the stop bit follows the data directly, and `rx_ninth` and `par_err` read 0.
- R7: `stop2`=1 with 6, 7 or 8 data bits makes the receiver sample two stop bits. With 5 data bits only one stop bit is sampled, so a new start bit may follow at once.
- R8: A low level at any sampled stop bit sets `frm_err`, and the word is still delivered with a single strobe.
- R9: `rx_valid` is high for exactly one clock per accepted frame. `rx_data`, `rx_ninth`, `par_err` and `frm_err` change only together with that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling strobe, OVS per bit time |
| rxd | input | 1 | Serial line, idle high |
| len_sel | input | 2 | Data length select (5 + value bits) |
| par_en | input | 1 | Parity bit present and checked |
| par_rule | input | 2 | Parity rule: even, odd, always-one, always-zero |
| xbit_en | input | 1 | Unchecked ninth bit present (parity off) |
| stop2 | input | 1 | Two stop bits for lengths 6 to 8 |
| rx_data | output | 8 | Received word, right-justified |
| rx_ninth | output | 1 | Received parity or extra bit |
| rx_valid | output | 1 | One-cycle frame-complete strobe |
| par_err | output | 1 | Parity mismatch on the last frame |
| frm_err | output | 1 | Low stop bit on the last frame |

## Verification
The bench builds the block with its defaults: sixteen ticks per bit, an eight-bit word, and a tick on every second clock. This makes the longest frame short enough to sweep every length against every framing choice and both stop settings, with several data patterns each. Expected words and parity bits are worked out by masking and reduction in the bench. Directed frames then add a corrupted parity bit under each rule, low stop bits, a short start glitch, and back-to-back five-bit frames with two stops selected.

// File: rtl/fr_rx_pkg.sv
package fr_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_EVEN  = 2'd0,
        PAR_ODD   = 2'd1,
        PAR_MARK  = 2'd2,
        PAR_SPACE = 2'd3
    } par_rule_e;

endpackage

// File: rtl/fr_sync.sv
module fr_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/fr_parity_eval.sv
module fr_parity_eval
    import fr_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] word,
    input  par_rule_e     rule,
    input  logic          bit_rx,
    output logic          ok
);
    logic expect_bit;

    always_comb begin
        unique case (rule)
            PAR_EVEN:  expect_bit = ^word;
            PAR_ODD:   expect_bit = ~^word;
            PAR_MARK:  expect_bit = 1'b1;
            default:   expect_bit = 1'b0;
        endcase
        ok = (bit_rx == expect_bit);
    end
endmodule

// File: rtl/cfg_uart_rx.sv
module cfg_uart_rx
    import fr_rx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic [1:0]    len_sel,
    input  logic          par_en,
    input  logic [1:0]    par_rule,
    input  logic          xbit_en,
    input  logic          stop2,
    output logic [DW-1:0] rx_data,
    output logic          rx_ninth,
    output logic          rx_valid,
    output logic          par_err,
    output logic          frm_err
);
    localparam int LEN_SEL_W = 2;
    localparam int LEN_STEPS = 1 << LEN_SEL_W;
    localparam int MIN_LEN   = DW - LEN_STEPS + 1;
    localparam int OS_W      = $clog2(OVS);
    localparam int BI_W      = $clog2(DW);
    localparam int HALF      = OVS / 2;

    typedef struct packed {
        rx_state_e            st;
        logic [OS_W-1:0]      os;
        logic [BI_W-1:0]      bidx;
        logic [DW-1:0]        sh;
        logic                 bit9;
        logic                 stop_more;
        logic                 stop_bad;
        logic                 prev;
        logic [LEN_SEL_W-1:0] len;
        logic                 par;
        par_rule_e            rule;
        logic                 xbit;
        logic                 two_stop;
        logic [DW-1:0]        dout;
        logic                 nout;
        logic                 vout;
        logic                 perr;
        logic                 ferr;
    } rx_regs_t;

    rx_regs_t state_d, state_q;

    logic                 line_s;
    logic [DW-1:0]        word_aligned;
    logic [BI_W-1:0]      last_idx;
    logic                 par_ok;
    logic [LEN_SEL_W-1:0] cur_len;
    logic                 cur_par;
    logic                 cur_xbit;

    fr_sync #(.STAGES(2), .RESET_VAL(1'b1)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    always_comb begin
        word_aligned = state_q.sh >> (LEN_SEL_W'(LEN_STEPS - 1) - state_q.len);
        last_idx     = BI_W'(MIN_LEN - 1) + BI_W'(state_q.len);
    end

    fr_parity_eval #(.DW(DW)) i_par (
        .word  (word_aligned),
        .rule  (state_q.rule),
        .bit_rx(state_q.bit9),
        .ok    (par_ok)
    );

    always_comb begin
        state_d      = state_q;
        state_d.vout = 1'b0;
        if (tick) begin
            state_d.prev = line_s;
            unique case (state_q.st)
                ST_IDLE: begin
                    if (state_q.prev && !line_s) begin
                        state_d.st       = ST_START;
                        state_d.os       = '0;
                        state_d.len      = len_sel;
                        state_d.par      = par_en;
                        state_d.rule     = par_rule_e'(par_rule);
                        state_d.xbit     = xbit_en && !par_en;
                        state_d.two_stop = stop2 && (len_sel != '0);
                    end
                end
                ST_START: begin
                    if (state_q.os == OS_W'(HALF - 1)) begin
                        state_d.os   = '0;
                        state_d.bidx = '0;
                        state_d.sh   = '0;
                        state_d.st   = line_s ? ST_IDLE : ST_DATA;
                    end else begin
                        state_d.os = state_q.os + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (state_q.os == OS_W'(OVS - 1)) begin
                        state_d.os   = '0;
                        state_d.sh   = {line_s, state_q.sh[DW-1:1]};
                        state_d.bidx = state_q.bidx + 1'b1;
                        if (state_q.bidx == last_idx) begin
                            state_d.bit9      = 1'b0;
                            state_d.stop_more = state_q.two_stop;
                            state_d.stop_bad  = 1'b0;
                            state_d.st = (state_q.par || state_q.xbit) ? ST_NINTH : ST_STOP;
                        end
                    end else begin
                        state_d.os = state_q.os + 1'b1;
                    end
                end
                ST_NINTH: begin
                    if (state_q.os == OS_W'(OVS - 1)) begin
                        state_d.os   = '0;
                        state_d.bit9 = line_s;
                        state_d.st   = ST_STOP;
                    end else begin
                        state_d.os = state_q.os + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (state_q.os == OS_W'(OVS - 1)) begin
                        state_d.os       = '0;
                        state_d.stop_bad = state_q.stop_bad || !line_s;
                        if (state_q.stop_more) begin
                            state_d.stop_more = 1'b0;
                        end else begin
                            state_d.st   = ST_IDLE;
                            state_d.dout = word_aligned;
                            state_d.nout = state_q.bit9;
                            state_d.perr = state_q.par && !par_ok;
                            state_d.ferr = state_q.stop_bad || !line_s;
                            state_d.vout = 1'b1;
                        end
                    end else begin
                        state_d.os = state_q.os + 1'b1;
                    end
                end
                default: state_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.st   <= ST_IDLE;
            state_q.prev <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign rx_data  = state_q.dout;
    assign rx_ninth = state_q.nout;
    assign rx_valid = state_q.vout;
    assign par_err  = state_q.perr;
    assign frm_err  = state_q.ferr;
    assign cur_len  = state_q.len;
    assign cur_par  = state_q.par;
    assign cur_xbit = state_q.xbit;
endmodule

// File: rtl/fr_rx_checker.sv
module fr_rx_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] rx_data,
    input logic          rx_ninth,
    input logic          rx_valid,
    input logic          par_err,
    input logic          frm_err,
    input logic [1:0]    cur_len,
    input logic          cur_par,
    input logic          cur_xbit
);
    localparam int MIN_LEN = DW - 3;

    assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_data) && $stable(rx_ninth) && $stable(par_err) && $stable(frm_err)));

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data >> (MIN_LEN + int'(cur_len))) == '0));

    assert_ninth_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cur_par && !cur_xbit) |-> !rx_ninth);

    assert_no_perr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cur_par) |-> !par_err);
endmodule

bind cfg_uart_rx fr_rx_checker #(.DW(DW)) i_fr_rx_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_data (rx_data),
    .rx_ninth(rx_ninth),
    .rx_valid(rx_valid),
    .par_err (par_err),
    .frm_err (frm_err),
    .cur_len (cur_len),
    .cur_par (cur_par),
    .cur_xbit(cur_xbit)
);

// File: tb/test_cfg_uart_rx.sv
module test_cfg_uart_rx;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 32;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] len_sel = '0;
    logic       par_en = 1'b0;
    logic [1:0] par_rule = '0;
    logic       xbit_en = 1'b0;
    logic       stop2 = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ninth, rx_valid, par_err, frm_err;

    int checks = 0;
    int errors = 0;
    int vtotal = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic [7:0] cap_d [4];
    logic       cap_n [4];
    logic       cap_p [4];
    logic       cap_f [4];

    cfg_uart_rx i_cfg_uart_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .len_sel(len_sel), .par_en(par_en), .par_rule(par_rule),
        .xbit_en(xbit_en), .stop2(stop2),
        .rx_data(rx_data), .rx_ninth(rx_ninth), .rx_valid(rx_valid),
        .par_err(par_err), .frm_err(frm_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= ~tick;
    end

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            cap_d[vtotal % 4] <= rx_data;
            cap_n[vtotal % 4] <= rx_ninth;
            cap_p[vtotal % 4] <= par_err;
            cap_f[vtotal % 4] <= frm_err;
            vtotal <= vtotal + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG && !done) begin
            done = 1'b1;
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired act=%0d exp<%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input bit has9,
                              input bit b9, input int nstop, input bit s1, input bit s2);
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(d[i]);
        if (has9) drive_bit(b9);
        drive_bit(s1);
        if (nstop == 2) drive_bit(s2);
    endtask

    function automatic logic [7:0] mask_of(input int nb);
        return 8'hFF >> (8 - nb);
    endfunction

    function automatic logic par_bit(input logic [7:0] w, input int rule);
        case (rule)
            0: return ^w;
            1: return ~^w;
            2: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // one frame, then idle; checks one strobe and all four outputs
    task automatic run_frame(input string req, input logic [7:0] d, input int nb,
                             input bit has9, input bit b9, input int nstop,
                             input bit s1, input bit s2,
                             input bit exp9, input bit expp, input bit expf);
        int base;
        int idx;
        base = vtotal;
        send_frame(d, nb, has9, b9, nstop, s1, s2);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        chk({req, " strobe count"}, vtotal - base, 1);
        idx = base % 4;
        chk({req, " data"}, int'(cap_d[idx]), int'(d & mask_of(nb)));
        chk({req, " ninth"}, int'(cap_n[idx]), int'(exp9));
        chk({req, " par_err"}, int'(cap_p[idx]), int'(expp));
        chk({req, " frm_err"}, int'(cap_f[idx]), int'(expf));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 reset valid", int'(rx_valid), 0);
        chk("R9 reset data", int'(rx_data), 0);
        chk("R9 reset flags", int'({rx_ninth, par_err, frm_err}), 0);

        // sweep: length x framing x stop setting x data patterns
        for (int ls = 0; ls < 4; ls++) begin
            for (int c = 0; c < 6; c++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int k = 0; k < 4; k++) begin
                        logic [7:0] d;
                        int nb;
                        bit has9;
                        bit b9;
                        int nst;
                        nb = 5 + ls;
                        case (k)
                            0: d = 8'h00;
                            1: d = 8'hFF;
                            2: d = 8'hA5;
                            default: d = 8'(ls * 37 + c * 11 + s * 5 + 3);
                        endcase
                        len_sel  = 2'(ls);
                        stop2    = s[0];
                        par_en   = (c >= 2);
                        par_rule = (c >= 2) ? 2'(c - 2) : 2'd0;
                        xbit_en  = (c == 1) || (c >= 2 && c[0]);
                        has9 = (c >= 1);
                        if (c == 1) b9 = d[0] ^ d[1] ^ k[0];
                        else        b9 = par_bit(d & mask_of(nb), c - 2);
                        nst = (s == 1 && nb > 5) ? 2 : 1;
                        if (c == 0)      run_frame("R2 R6 R7 sweep plain", d, nb, 0, 0, nst, 1, 1, 0, 0, 0);
                        else if (c == 1) run_frame("R2 R4 sweep extra bit", d, nb, 1, b9, nst, 1, 1, b9, 0, 0);
                        else if (xbit_en) run_frame("R3 R5 sweep parity with extra enable", d, nb, 1, b9, nst, 1, 1, b9, 0, 0);
                        else             run_frame("R3 sweep parity", d, nb, 1, b9, nst, 1, 1, b9, 0, 0);
                    end
                end
            end
        end

        // corrupted parity under each rule, lengths 8 and 5
        stop2 = 1'b0;
        xbit_en = 1'b0;
        par_en = 1'b1;
        for (int r = 0; r < 4; r++) begin
            for (int j = 0; j < 2; j++) begin
                logic [7:0] d;
                int nb;
                logic bad;
                nb = j ? 5 : 8;
                len_sel = j ? 2'd0 : 2'd3;
                par_rule = 2'(r);
                d = 8'h6C ^ 8'(r);
                bad = ~par_bit(d & mask_of(nb), r);
                run_frame("R3 parity mismatch", d, nb, 1, bad, 1, 1, 1, bad, 1, 0);
            end
        end

        // framing errors
        par_en = 1'b0;
        len_sel = 2'd3;
        stop2 = 1'b0;
        run_frame("R8 low single stop", 8'h3C, 8, 0, 0, 1, 0, 1, 0, 0, 1);
        len_sel = 2'd1;
        stop2 = 1'b1;
        run_frame("R7 R8 low second stop", 8'h15, 6, 0, 0, 2, 1, 0, 0, 0, 1);
        run_frame("R7 R8 low first stop", 8'h2A, 6, 0, 0, 2, 0, 1, 0, 0, 1);

        // five-bit length with two stops selected: one stop, next frame follows at once
        begin
            int base;
            len_sel = 2'd0;
            stop2 = 1'b1;
            base = vtotal;
            send_frame(8'h13, 5, 0, 0, 1, 1, 1);
            send_frame(8'h0C, 5, 0, 0, 1, 1, 1);
            rxd = 1'b1;
            repeat (40) @(negedge clk);
            chk("R7 back-to-back strobes", vtotal - base, 2);
            chk("R7 first word", int'(cap_d[base % 4]), 8'h13);
            chk("R7 first frm_err", int'(cap_f[base % 4]), 0);
            chk("R7 second word", int'(cap_d[(base + 1) % 4]), 8'h0C);
            chk("R7 second frm_err", int'(cap_f[(base + 1) % 4]), 0);
        end

        // start glitch shorter than half a bit
        begin
            int base;
            base = vtotal;
            rxd = 1'b0;
            repeat (8) @(negedge clk);
            rxd = 1'b1;
            repeat (400) @(negedge clk);
            chk("R1 glitch gives no strobe", vtotal - base, 0);
            chk("R9 data held after glitch", int'(rx_data), 8'h0C);
        end
        len_sel = 2'd3;
        stop2 = 1'b0;
        run_frame("R1 frame after glitch", 8'h81, 8, 0, 0, 1, 1, 1, 0, 0, 0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule